// File: doc/BRIEF.md
# Two-Key Register Write Guard

This block sits on the write path of a peripheral register file and decides whether each write may reach it. It holds two kick slots, each at its own word address. A slot is armed only while the last value written to it equals that slot's 32-bit key. The guard is open only while both slots are armed. While it is closed, every write to a protected address is dropped without any error. Writes to the kick addresses themselves are always accepted.

Software opens the guard by writing the first key to the first kick address and then the second key to the second kick address. It closes the guard again by writing zero to the kick addresses. The block also sits on the read return path. It replaces the data of any read that targets a kick address with zero, so the keys cannot be read back. All other reads pass through unchanged, whether the guard is open or closed. A level output reports the current lock state.

Top module: `wp_unlock_gate`

## Requirements
- R1: After reset both slots are disarmed, so `unlocked` is 0 and protected writes are dropped.
- R2: `unlocked` is 1 exactly when both slots are armed. A slot is armed or disarmed by the latest write to its address alone, so the keys may arrive in either order. `unlocked` changes in the cycle after the clock edge that captures the kick write.
- R3: Writing 0x83E70B13 to byte address 0x6C and then 0x95A4F1E0 to byte address 0x70 sets `unlocked` to 1. The first of these writes alone leaves it at 0.
- R4: Writing zero to either kick address disarms that slot and sets `unlocked` to 0 in the next cycle.
- R5: Any value other than the slot's exact key disarms that slot. This includes a key with one bit flipped and the two keys written to each other's addresses.
- R6: While `unlocked` is 0, `prot_wr_en` stays 0 for a write to any non-kick address.
- R7: While `unlocked` is 1, a write to a non-kick address raises `prot_wr_en` in the same cycle, with `prot_wr_addr` and `prot_wr_data` equal to the incoming address and data.
- R8: A write to a kick address never raises `prot_wr_en`.
- R9: `rd_data` is zero when `rd_addr` is a kick address. Otherwise it equals `rf_rd_data`, whatever the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the register write port |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rf_rd_data | input | DATA_W | Read data returned by the protected register file |
| prot_wr_en | output | 1 | Write strobe forwarded to the protected register file |
| prot_wr_addr | output | ADDR_W | Forwarded write address |
| prot_wr_data | output | DATA_W | Forwarded write data |
| rd_data | output | DATA_W | Read data after kick masking |
| unlocked | output | 1 | 1 while both slots hold their keys |

## Verification
The bench flips each of the 32 bits of each key in turn, and it writes the two keys to each other's addresses. A design that compared only part of a key, or that checked a value without regard to which slot received it, would open on one of those values. It sweeps every word address while locked and while unlocked. That sweep exposes a decoder that forwards kick writes, or one that leaks writes to addresses near the kick pair. It also unlocks with the keys in reverse order and relocks through each slot on its own. A design that tracked a sequence, or that needed both slots cleared before it closed, would show the wrong `unlocked` value one cycle after the kick write. Finally, a full read sweep shows whether key data ever appears on `rd_data`.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic {
    WP_LOCKED = 1'b0,
    WP_OPEN   = 1'b1
  } wp_state_e;

  localparam int unsigned WP_SLOTS = 2;
endpackage

// File: rtl/wp_kick_slot.sv
module wp_kick_slot #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] SLOT_ADDR = '0,
  parameter logic [DATA_W-1:0] SLOT_KEY  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              slot_hit,
  output logic              slot_armed
);
  // exact full-width comparison against the key
  function automatic logic key_equal(input logic [DATA_W-1:0] v);
    return (v == SLOT_KEY);
  endfunction

  logic load_good;

  assign slot_hit  = wr_en && (wr_addr == SLOT_ADDR);
  assign load_good = key_equal(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n)        slot_armed <= 1'b0;
    else if (slot_hit) slot_armed <= load_good;
  end

  assert_key_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SLOT_ADDR && wr_data == SLOT_KEY) |=> slot_armed);

  assert_bad_value_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SLOT_ADDR && wr_data != SLOT_KEY) |=> !slot_armed);

  assert_zero_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SLOT_ADDR && wr_data == '0) |=> !slot_armed);

  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == SLOT_ADDR) |=> $stable(slot_armed));
endmodule

// File: rtl/wp_read_filter.sv
module wp_read_filter #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] MASK_ADDR_A = '0,
  parameter logic [ADDR_W-1:0] MASK_ADDR_B = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_is_kick
);
  function automatic logic masked_addr(input logic [ADDR_W-1:0] a);
    return (a == MASK_ADDR_A) || (a == MASK_ADDR_B);
  endfunction

  assign rd_is_kick = masked_addr(rd_addr);
  assign rd_data    = rd_is_kick ? '0 : rf_rd_data;

  assert_kick_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == MASK_ADDR_A || rd_addr == MASK_ADDR_B) |-> (rd_data == '0));

  assert_other_read_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != MASK_ADDR_A && rd_addr != MASK_ADDR_B) |-> (rd_data == rf_rd_data));
endmodule

// File: rtl/wp_unlock_gate.sv
module wp_unlock_gate
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] KICK0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KICK1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY0 = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1 = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              prot_wr_en,
  output logic [ADDR_W-1:0] prot_wr_addr,
  output logic [DATA_W-1:0] prot_wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              unlocked
);
  localparam logic [ADDR_W-1:0] SLOT_ADDR_TBL [WP_SLOTS] = '{KICK0_ADDR, KICK1_ADDR};
  localparam logic [DATA_W-1:0] SLOT_KEY_TBL  [WP_SLOTS] = '{KEY0, KEY1};

  function automatic logic is_kick_addr(input logic [ADDR_W-1:0] a);
    return (a == KICK0_ADDR) || (a == KICK1_ADDR);
  endfunction

  logic [WP_SLOTS-1:0] slot_hit;
  logic [WP_SLOTS-1:0] slot_armed;
  logic                any_kick_hit;
  logic                wr_targets_kick;
  logic                rd_is_kick;
  wp_state_e           gate_state;

  for (genvar g = 0; g < WP_SLOTS; g++) begin : g_slot
    wp_kick_slot #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SLOT_ADDR(SLOT_ADDR_TBL[g]),
      .SLOT_KEY (SLOT_KEY_TBL[g])
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .slot_hit  (slot_hit[g]),
      .slot_armed(slot_armed[g])
    );
  end

  assign any_kick_hit    = |slot_hit;
  assign wr_targets_kick = is_kick_addr(wr_addr);
  assign gate_state      = (&slot_armed) ? WP_OPEN : WP_LOCKED;
  assign unlocked        = (gate_state == WP_OPEN);

  assign prot_wr_en   = wr_en && !wr_targets_kick && unlocked;
  assign prot_wr_addr = wr_addr;
  assign prot_wr_data = wr_data;

  wp_read_filter #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MASK_ADDR_A(KICK0_ADDR),
    .MASK_ADDR_B(KICK1_ADDR)
  ) u_rd_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (rd_addr),
    .rf_rd_data(rf_rd_data),
    .rd_data   (rd_data),
    .rd_is_kick(rd_is_kick)
  );

  assert_locked_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(&slot_armed) |-> !prot_wr_en);

  assert_kick_not_forwarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_kick_hit |-> !prot_wr_en);

  assert_open_forwards_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&slot_armed) && !any_kick_hit) |-> prot_wr_en);

  assert_open_needs_kick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(any_kick_hit));

  assert_read_mask_consistent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_kick |-> (rd_data == '0));
endmodule

// File: tb/wp_unlock_gate_tb.sv
module wp_unlock_gate_tb;
  localparam logic [7:0]  K0A  = 8'h6C;
  localparam logic [7:0]  K1A  = 8'h70;
  localparam logic [31:0] KEY0 = 32'h83E7_0B13;
  localparam logic [31:0] KEY1 = 32'h95A4_F1E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rf_rd_data = '0;
  logic        prot_wr_en;
  logic [7:0]  prot_wr_addr;
  logic [31:0] prot_wr_data;
  logic [31:0] rd_data;
  logic        unlocked;

  int total = 0;
  int bad = 0;
  logic m_k0 = 1'b0;
  logic m_k1 = 1'b0;

  always #2.5 clk = ~clk;

  wp_unlock_gate u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rf_rd_data(rf_rd_data), .prot_wr_en(prot_wr_en),
    .prot_wr_addr(prot_wr_addr), .prot_wr_data(prot_wr_data), .rd_data(rd_data),
    .unlocked(unlocked)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string ltag);
    bit kick;
    bit exp_en;
    string tag;
    kick = (a == K0A) || (a == K1A);
    exp_en = !kick && m_k0 && m_k1;
    tag = kick ? "R8" : (exp_en ? "R7" : "R6");
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1;
    check(prot_wr_en == exp_en, tag, 32'(prot_wr_en), 32'(exp_en));
    if (exp_en) begin
      check(prot_wr_addr == a, "R7 addr", 32'(prot_wr_addr), 32'(a));
      check(prot_wr_data == d, "R7 data", prot_wr_data, d);
    end
    @(posedge clk);
    if (a == K0A) m_k0 = (d == KEY0);
    if (a == K1A) m_k1 = (d == KEY1);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check(unlocked == (m_k0 && m_k1), ltag, 32'(unlocked), 32'(m_k0 && m_k1));
  endtask

  task automatic read_sweep();
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a);
      rf_rd_data = {24'hC3A55A, 8'(a)} ^ 32'(a * 7);
      #1;
      if (a == K0A || a == K1A)
        check(rd_data == 32'h0, "R9 kick read", rd_data, 32'h0);
      else
        check(rd_data == rf_rd_data, "R9 pass read", rd_data, rf_rd_data);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(unlocked == 1'b0, "R1 in reset", 32'(unlocked), 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(unlocked == 1'b0, "R1 after reset", 32'(unlocked), 32'h0);
    do_write(8'h10, 32'hDEAD_BEEF, "R1");

    // locked sweep over every word address; kick slots get non-key data
    for (int w = 0; w < 64; w++) do_write(8'(w * 4), 32'h1000 + 32'(w), "R6");

    // first key alone is not enough, second opens
    do_write(K0A, KEY0, "R3 one key");
    do_write(K1A, KEY1, "R3 both keys");

    // open sweep, skipping kick addresses
    for (int w = 0; w < 64; w++)
      if (8'(w * 4) != K0A && 8'(w * 4) != K1A)
        do_write(8'(w * 4), 32'h5A00_0000 | 32'(w), "R7");

    read_sweep();

    // relock through each slot alone
    do_write(K0A, 32'h0, "R4 zero slot0");
    do_write(K0A, KEY0, "R2 rearm slot0");
    do_write(K1A, 32'h0, "R4 zero slot1");
    do_write(K1A, KEY1, "R2 rearm slot1");

    // single-bit corruptions of each key
    for (int i = 0; i < 32; i++) begin
      do_write(K0A, KEY0 ^ (32'h1 << i), "R5 flip key0");
      do_write(K0A, KEY0, "R2 restore key0");
    end
    for (int i = 0; i < 32; i++) begin
      do_write(K1A, KEY1 ^ (32'h1 << i), "R5 flip key1");
      do_write(K1A, KEY1, "R2 restore key1");
    end

    // swapped keys
    do_write(K0A, KEY1, "R5 swap0");
    do_write(K1A, KEY0, "R5 swap1");
    do_write(8'h20, 32'h1234_5678, "R6");

    // reverse order unlock
    do_write(K1A, KEY1, "R2 reverse first");
    do_write(K0A, KEY0, "R2 reverse second");
    do_write(8'h24, 32'h8765_4321, "R7");

    // both zero relocks; reads still pass while locked
    do_write(K0A, 32'h0, "R4 zero both a");
    do_write(K1A, 32'h0, "R4 zero both b");
    read_sweep();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule